// File: doc/BRIEF.md
# CAN Controller Initialization Gate

This block holds the control register, a status register and the two error counters of one CAN controller, and decides when the host may change the controller's configuration. Bit 0 of the control register is the software-initialization bit. While it is set, the protocol engine is held offline, the transmit pin is forced to the recessive level, and the host may rewrite the bus-timing and message configuration registers. When software clears the bit, the engine is released one clock later. From then on, configuration writes are refused and flagged.

The host reaches the block over a synchronous 8-bit register bus: an address, a write strobe with write data, and read data that appears one clock after the address. The error counters are incremented and decremented by single-cycle pulses from the protocol engine. While the initialization bit is set, one host write can preset both counters to a common value. Setting the bit does not clear the counters.

Top module: `can_init_gate`

## Requirements
- R1: A synchronous reset sets the control register to 0x0B (initialization bit 0 set), clears the status register (address 0x01), the transmit error counter (address 0x02) and the receive error counter (address 0x03) to 0x00, holds `eng_online` low, holds `can_tx` at 1 and holds `wr_reject` low.
- R2: In every cycle in which the initialization bit is 1, `can_tx` is 1 and `eng_online` is 0.
- R3: A write that sets the initialization bit leaves both error counters unchanged, and so does any engine pulse in the cycle of that write.
- R4: While the initialization bit is 1, a write to address 0x02 loads the written 8-bit value into both the transmit and the receive error counter. Address 0x03 is read-only: writes to it never change it.
- R5: While the initialization bit is 1, writes to the configuration registers at addresses 0x04 to 0x13 are stored, and a read of the same address returns the stored value.
- R6: While the initialization bit is 0, writes to addresses 0x02 and 0x04 to 0x13 change nothing, and `wr_reject` is 1 for exactly the one cycle after the refused write. Writes to the control register at 0x00 are always accepted, and a write to any other address never raises `wr_reject`.
- R7: After the write that clears the initialization bit, `eng_online` and `can_tx` keep their offline values (0 and 1) for one more clock. After that, `eng_online` is 1 and `can_tx` follows `eng_tx` with a one-clock delay.
- R8: Increment and decrement pulses change a counter by one only while `eng_online` is 1 and no write is setting the initialization bit. An increment and a decrement on the same counter in the same cycle leave it unchanged.
- R9: The error counters saturate: an increment at 255 keeps 255, and a decrement at 0 keeps 0.
- R10: The status register reads bit 0 = `eng_online`, bit 1 = transmit count ≥ 96, bit 2 = receive count ≥ 96, and 0 in bits 7 to 3.
- R11: `host_rdata` shows the register at the address that was presented one clock earlier. Addresses outside 0x00 to 0x13 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 6 | Register address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, one clock after the address |
| wr_reject | output | 1 | One-cycle flag for a refused configuration write |
| eng_tx | input | 1 | Transmit level requested by the protocol engine |
| tec_inc | input | 1 | Transmit error counter increment pulse |
| tec_dec | input | 1 | Transmit error counter decrement pulse |
| rec_inc | input | 1 | Receive error counter increment pulse |
| rec_dec | input | 1 | Receive error counter decrement pulse |
| eng_online | output | 1 | Protocol engine enable |
| can_tx | output | 1 | Transmit pin, 1 is recessive |

## Verification
The assertions assume that every input is a known value at each rising edge and that reset lasts at least one clock. They also assume that an engine pulse held high for several cycles means several pulses, so no pulse width is taken for granted. The stimulus changes every input only at falling edges and keeps the write strobe low during reset. Engine pulses are raised only in cycles chosen to test the gating, including the cycle of the write that sets the initialization bit.

// File: rtl/can_init_pkg.sv
package can_init_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [DATA_W-1:0] CTRL_RESET = 8'h0B;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_STAT = 1;
  localparam int unsigned A_TEC  = 2;
  localparam int unsigned A_REC  = 3;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_STAT,
    SEL_TEC,
    SEL_REC,
    SEL_CFG,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/cig_ctrl.sv
module cig_ctrl
  import can_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              eng_tx,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              init_bit,
  output logic              eng_online,
  output logic              cnt_en,
  output logic              can_tx
);
  logic init_next;
  logic run_next;

  assign init_next = wr_en ? wdata[0] : ctrl_q[0];
  // engine runs only when the bit was already clear and stays clear
  assign run_next  = ~init_next & ~ctrl_q[0];
  assign init_bit  = ctrl_q[0];
  assign cnt_en    = eng_online & ~init_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= CTRL_RESET;
      eng_online <= 1'b0;
      can_tx     <= 1'b1;
    end else begin
      if (wr_en) ctrl_q <= wdata;
      eng_online <= run_next;
      can_tx     <= run_next ? eng_tx : 1'b1;
    end
  end
endmodule

// File: rtl/cig_err_ctr.sv
module cig_err_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          en,
  input  logic          up,
  input  logic          dn,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_MIN = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= CNT_MIN;
    end else if (load) begin
      count <= load_val;
    end else if (en && up && !dn && count != CNT_MAX) begin
      count <= count + CW'(1);
    end else if (en && dn && !up && count != CNT_MIN) begin
      count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/cig_cfg_ram.sv
module cig_cfg_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/can_init_gate.sv
module can_init_gate
  import can_init_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int CFG_BASE = 4,
  parameter int CFG_NUM  = 16,
  parameter int WARN_LVL = 96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              wr_reject,
  input  logic              eng_tx,
  input  logic              tec_inc,
  input  logic              tec_dec,
  input  logic              rec_inc,
  input  logic              rec_dec,
  output logic              eng_online,
  output logic              can_tx
);
  localparam int CFG_AW = (CFG_NUM > 1) ? $clog2(CFG_NUM) : 1;
  localparam int CMP_W  = ADDR_W + 1;
  localparam logic [CMP_W-1:0] CFG_LO = CMP_W'(CFG_BASE);
  localparam logic [CMP_W-1:0] CFG_HI = CMP_W'(CFG_BASE + CFG_NUM);
  localparam logic [DATA_W-1:0] WARN = DATA_W'(WARN_LVL);

  reg_sel_e          sel;
  logic              guarded;
  logic              ctrl_wr;
  logic              tec_load;
  logic              cfg_we;
  logic [CFG_AW-1:0] cfg_idx;
  logic [DATA_W-1:0] ctrl_q;
  logic              init_bit;
  logic              cnt_en;
  logic [DATA_W-1:0] cfg_rd;
  logic [DATA_W-1:0] reg_rd_q;
  logic              cfg_sel_q;
  logic [DATA_W-1:0] tec_cnt;
  logic [DATA_W-1:0] rec_cnt;
  logic [DATA_W-1:0] status;
  logic [1:0]        up_v;
  logic [1:0]        dn_v;
  logic [DATA_W-1:0] cnt_v [2];

  // address decode
  always_comb begin
    sel = SEL_NONE;
    if (host_addr == ADDR_W'(A_CTRL))      sel = SEL_CTRL;
    else if (host_addr == ADDR_W'(A_STAT)) sel = SEL_STAT;
    else if (host_addr == ADDR_W'(A_TEC))  sel = SEL_TEC;
    else if (host_addr == ADDR_W'(A_REC))  sel = SEL_REC;
    else if ({1'b0, host_addr} >= CFG_LO && {1'b0, host_addr} < CFG_HI) sel = SEL_CFG;
  end

  assign cfg_idx  = CFG_AW'(host_addr - ADDR_W'(CFG_BASE));
  assign guarded  = (sel == SEL_TEC) || (sel == SEL_CFG);
  assign ctrl_wr  = host_wr && (sel == SEL_CTRL);
  assign tec_load = host_wr && init_bit && (sel == SEL_TEC);
  assign cfg_we   = host_wr && init_bit && (sel == SEL_CFG);

  cig_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (ctrl_wr),
    .wdata      (host_wdata),
    .eng_tx     (eng_tx),
    .ctrl_q     (ctrl_q),
    .init_bit   (init_bit),
    .eng_online (eng_online),
    .cnt_en     (cnt_en),
    .can_tx     (can_tx)
  );

  assign up_v = {rec_inc, tec_inc};
  assign dn_v = {rec_dec, tec_dec};

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    cig_err_ctr #(.CW(DATA_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (tec_load),
      .load_val (host_wdata),
      .en       (cnt_en),
      .up       (up_v[g]),
      .dn       (dn_v[g]),
      .count    (cnt_v[g])
    );
  end

  assign tec_cnt = cnt_v[0];
  assign rec_cnt = cnt_v[1];

  cig_cfg_ram #(.DEPTH(CFG_NUM), .DW(DATA_W)) u_cfg (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_idx),
    .wdata (host_wdata),
    .raddr (cfg_idx),
    .rdata (cfg_rd)
  );

  assign status = {5'b0, rec_cnt >= WARN, tec_cnt >= WARN, eng_online};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q  <= '0;
      cfg_sel_q <= 1'b0;
      wr_reject <= 1'b0;
    end else begin
      cfg_sel_q <= (sel == SEL_CFG);
      wr_reject <= host_wr && guarded && !init_bit;
      unique case (sel)
        SEL_CTRL: reg_rd_q <= ctrl_q;
        SEL_STAT: reg_rd_q <= status;
        SEL_TEC:  reg_rd_q <= tec_cnt;
        SEL_REC:  reg_rd_q <= rec_cnt;
        default:  reg_rd_q <= '0;
      endcase
    end
  end

  assign host_rdata = cfg_sel_q ? cfg_rd : reg_rd_q;
endmodule

// File: rtl/cig_checker.sv
module cig_checker #(
  parameter int ADDR_W   = 6,
  parameter int CFG_BASE = 4,
  parameter int CFG_NUM  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic [7:0]        host_wdata,
  input logic              wr_reject,
  input logic              init_bit,
  input logic              eng_online,
  input logic              can_tx,
  input logic [7:0]        tec,
  input logic [7:0]        rec
);
  logic at_tec;
  logic at_cfg;
  logic loading;

  assign at_tec  = (int'(host_addr) == 2);
  assign at_cfg  = (int'(host_addr) >= CFG_BASE) && (int'(host_addr) < CFG_BASE + CFG_NUM);
  assign loading = host_wr && init_bit && at_tec;

  a_r2_tx_recessive: assert property (@(posedge clk) disable iff (rst)
    init_bit |-> (can_tx && !eng_online));

  a_r3_set_keeps_counts: assert property (@(posedge clk) disable iff (rst)
    $rose(init_bit) |-> ($stable(tec) && $stable(rec)));

  a_r4_shared_load: assert property (@(posedge clk) disable iff (rst)
    loading |=> (tec == $past(host_wdata) && rec == $past(host_wdata)));

  a_r6_reject_cause: assert property (@(posedge clk) disable iff (rst)
    wr_reject |-> $past(host_wr && !init_bit && (at_tec || at_cfg)));

  a_r6_reject_raised: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !init_bit && (at_tec || at_cfg)) |=> wr_reject);

  a_r7_release_delay: assert property (@(posedge clk) disable iff (rst)
    ($past(init_bit) && !init_bit) |-> (!eng_online && can_tx));

  a_r8_offline_hold: assert property (@(posedge clk) disable iff (rst)
    (!eng_online && !loading) |=> ($stable(tec) && $stable(rec)));

  a_r9_tec_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (tec == 8'hFF && !loading) |=> (tec != 8'h00));

  a_r9_rec_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (rec == 8'h00 && !loading) |=> (rec != 8'hFF));
endmodule

bind can_init_gate cig_checker #(
  .ADDR_W   (ADDR_W),
  .CFG_BASE (CFG_BASE),
  .CFG_NUM  (CFG_NUM)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .wr_reject  (wr_reject),
  .init_bit   (init_bit),
  .eng_online (eng_online),
  .can_tx     (can_tx),
  .tec        (tec_cnt),
  .rec        (rec_cnt)
);

// File: tb/sim_can_init_gate.sv
module sim_can_init_gate;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       wr;
    logic [5:0] addr;
    logic [7:0] wd;
    logic       rej;
    logic [5:0] ra;
    logic [7:0] ex;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 6'd4,  8'h5A, 1'b0, 6'd4,  8'h5A, 4'd5},  // R5 first cfg
    '{1'b1, 6'd19, 8'hC3, 1'b0, 6'd19, 8'hC3, 4'd5},  // R5 last cfg
    '{1'b1, 6'd2,  8'h40, 1'b0, 6'd3,  8'h40, 4'd4},  // R4 shared load
    '{1'b1, 6'd3,  8'h99, 1'b0, 6'd3,  8'h40, 4'd4},  // R4 rec read-only
    '{1'b1, 6'd0,  8'h0A, 1'b0, 6'd0,  8'h0A, 4'd6},  // R6 clear init
    '{1'b0, 6'd0,  8'h00, 1'b0, 6'd1,  8'h01, 4'd10}, // R10 online
    '{1'b1, 6'd4,  8'h11, 1'b1, 6'd4,  8'h5A, 4'd6},  // R6 cfg refused
    '{1'b1, 6'd2,  8'h77, 1'b1, 6'd2,  8'h40, 4'd6},  // R6 tec refused
    '{1'b1, 6'd0,  8'h0B, 1'b0, 6'd2,  8'h40, 4'd3},  // R3 set keeps tec
    '{1'b0, 6'd0,  8'h00, 1'b0, 6'd3,  8'h40, 4'd3},  // R3 set keeps rec
    '{1'b1, 6'd2,  8'h70, 1'b0, 6'd1,  8'h06, 4'd10}, // R10 warn bits
    '{1'b1, 6'd63, 8'hFF, 1'b0, 6'd63, 8'h00, 4'd11}, // R11 unmapped
    '{1'b1, 6'd4,  8'h22, 1'b0, 6'd4,  8'h22, 4'd5},  // R5 rewrite
    '{1'b1, 6'd2,  8'h00, 1'b0, 6'd2,  8'h00, 4'd4}   // R4 restore
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] host_addr = '0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       wr_reject;
  logic       eng_tx = 1'b0;
  logic       tec_inc = 1'b0, tec_dec = 1'b0, rec_inc = 1'b0, rec_dec = 1'b0;
  logic       eng_online;
  logic       can_tx;

  int n_run = 0;
  int n_fail = 0;

  can_init_gate u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .wr_reject(wr_reject),
    .eng_tx(eng_tx), .tec_inc(tec_inc), .tec_dec(tec_dec),
    .rec_inc(rec_inc), .rec_dec(rec_dec), .eng_online(eng_online), .can_tx(can_tx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk);
    host_wr = 1'b0; host_addr = a;
    @(negedge clk);
    v = host_rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      host_wr = VEC[i].wr; host_addr = VEC[i].addr; host_wdata = VEC[i].wd;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d reject", VEC[i].rq, i), int'(wr_reject), int'(VEC[i].rej));
      host_wr = 1'b0; host_addr = VEC[i].ra;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d read", VEC[i].rq, i), int'(host_rdata), int'(VEC[i].ex));
    end

    // R2: init set, engine asks for dominant, pin stays recessive
    eng_tx = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 can_tx while init", int'(can_tx), 1);
    chk("R2 offline while init", int'(eng_online), 0);

    // R7: release timing
    wr(6'd2, 8'hFE);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 6'd0; host_wdata = 8'h0A;
    @(negedge clk);
    host_wr = 1'b0;
    chk("R7 still offline", int'(eng_online), 0);
    chk("R7 still recessive", int'(can_tx), 1);
    @(negedge clk);
    chk("R7 online", int'(eng_online), 1);
    chk("R7 tx follows low", int'(can_tx), 0);
    eng_tx = 1'b1;
    @(negedge clk);
    chk("R7 tx follows high", int'(can_tx), 1);
    eng_tx = 1'b0;

    // R9: saturate at 255
    tec_inc = 1'b1; rec_inc = 1'b1;
    repeat (3) @(negedge clk);
    tec_inc = 1'b0; rec_inc = 1'b0;
    rd(6'd2, v); chk("R9 tec top", int'(v), 8'hFF);
    rd(6'd3, v); chk("R9 rec top", int'(v), 8'hFF);

    // R8: one decrement, then simultaneous pulses
    @(negedge clk); tec_dec = 1'b1;
    @(negedge clk); tec_dec = 1'b0;
    rd(6'd2, v); chk("R8 tec decrement", int'(v), 8'hFE);
    @(negedge clk); tec_inc = 1'b1; tec_dec = 1'b1;
    repeat (2) @(negedge clk);
    tec_inc = 1'b0; tec_dec = 1'b0;
    rd(6'd2, v); chk("R8 inc+dec no change", int'(v), 8'hFE);

    // R9: saturate at 0
    rec_dec = 1'b1;
    repeat (260) @(negedge clk);
    rec_dec = 1'b0;
    rd(6'd3, v); chk("R9 rec floor", int'(v), 8'h00);

    // R3: pulse during the setting write is dropped
    @(negedge clk);
    host_wr = 1'b1; host_addr = 6'd0; host_wdata = 8'h0B; tec_inc = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    // R8: pulses while offline are dropped
    repeat (4) @(negedge clk);
    tec_inc = 1'b0;
    rd(6'd2, v); chk("R3 R8 tec kept offline", int'(v), 8'hFE);
    chk("R2 recessive after set", int'(can_tx), 1);

    // R1: reset from a dirty state
    wr(6'd0, 8'hF1);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 tx recessive in reset", int'(can_tx), 1);
    chk("R1 offline in reset", int'(eng_online), 0);
    chk("R1 no reject in reset", int'(wr_reject), 0);
    rst = 1'b0;
    rd(6'd0, v); chk("R1 ctrl reset", int'(v), 8'h0B);
    rd(6'd1, v); chk("R1 status reset", int'(v), 8'h00);
    rd(6'd2, v); chk("R1 tec reset", int'(v), 8'h00);
    rd(6'd3, v); chk("R1 rec reset", int'(v), 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule